// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a 256K x 8 asynchronous static RAM. It turns one read or write request at a time into strobe sequences whose widths meet the memory's access, pulse and turnaround limits. The memory has a select of each polarity (one active low, one active high), an active-low write strobe, an active-low output-enable strobe and one shared byte-wide data bus. The data bus is split at the controller into an outgoing byte, an incoming byte and a driver enable.

Every analogue timing limit is a parameter in nanoseconds. At elaboration each limit becomes a cycle count, rounded up, against the clock period parameter. The host side is a valid/ready request channel that carries a write flag, an 18-bit address and a write byte. Read results come back as a one-cycle valid pulse carrying the byte. Only one access is in flight at a time. Address and data are held in registers from the moment the request is accepted, so the host may change its inputs at once.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and until the first request is accepted, mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: The memory counts as selected only when mem_cs1_n=0 and mem_cs2=1. Whenever req_ready is 1, the memory is deselected (mem_cs1_n=1, mem_cs2=0) and mem_dq_oe=0.
- R3: A read drives select, mem_oe_n=0 and mem_we_n=1 for exactly RD cycles, where RD is the largest of ceil(tRC), ceil(tAA), ceil(tACS) and ceil(tOE) in clock periods (9 at defaults). The byte on mem_dq_in at the last of those cycles is returned on rsp_rdata, with rsp_valid high for exactly one cycle. That cycle is the one RD clock edges after the accepting edge.
- R4: A write asserts select one cycle before mem_we_n falls. mem_we_n then stays low for exactly WP cycles, the largest of ceil(tWP), ceil(tCW), ceil(tAW) and ceil(tDW) (8 at defaults). mem_we_n and select are released together, and mem_oe_n stays 1 for the whole write. The byte written is the one accepted with the request.
- R5: mem_dq_oe rises on the edge where mem_we_n falls and falls on the edge where mem_we_n rises. It is never 1 at any other time.
- R6: mem_addr and mem_dq_out hold the values captured at acceptance for the whole access. Changes to the host inputs after acceptance have no effect on the access.
- R7: After a read, select and mem_oe_n stay inactive for HZ = ceil(tHZ) cycles (3 at defaults) before req_ready returns. The controller driver never overlaps the memory's output drive, including its high-Z tail.
- R8: After a write, all strobes stay inactive for REC cycles, where REC = max(1, ceil(tWC) - WP - 1) (1 at defaults), before req_ready returns.
- R9: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays low for RD+HZ cycles after a read (12 at defaults) and for 1+WP+REC cycles after a write (10 at defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 18 | Memory address |
| mem_cs1_n | output | 1 | Active-low memory select |
| mem_cs2 | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the memory bus |
| mem_dq_oe | output | 1 | Controller bus driver enable |
| mem_dq_in | input | 8 | Byte read from the memory bus |

## Verification
A behavioural reference in the bench records the accepting edge of each request. It predicts that req_ready falls on the next cycle and returns exactly RD+HZ or 1+WP+REC cycles later. It predicts that rsp_valid appears exactly RD cycles after a read is accepted, and compares both against the design every cycle at the falling edge. The bench's memory model returns correct data only once the read strobes have been held for RD cycles, so a capture one cycle early reads a wrong byte. The model also measures each write pulse and flags any overlap between the controller driver and its own output, including the HZ-cycle tail after a read.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_HZ, ST_WR_SET, ST_WR_PULSE, ST_WR_REC
  } seq_state_t;

  typedef struct packed {
    logic sel;
    logic wr;
    logic oe;
    logic drv;
  } strobe_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int width_for(input int v);
    return $clog2(v + 1) + 1;
  endfunction

  // strobe levels that belong to each sequencer phase
  function automatic strobe_t strobe_of(input seq_state_t s);
    strobe_t o;
    o = '0;
    case (s)
      ST_RD:       begin o.sel = 1'b1; o.oe = 1'b1; end
      ST_WR_SET:   o.sel = 1'b1;
      ST_WR_PULSE: begin o.sel = 1'b1; o.wr = 1'b1; o.drv = 1'b1; end
      default:     o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 9,
  parameter int HZ_CYC  = 3,
  parameter int WP_CYC  = 8,
  parameter int REC_CYC = 1,
  parameter int CNT_W   = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    start_wr,
  output logic    idle,
  output logic    capture,
  output strobe_t strb
);
  localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HZ  = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC = CNT_W'(REC_CYC - 1);

  seq_state_t       st_q, st_nx;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  always_comb begin
    st_nx  = st_q;
    t_load = 1'b0;
    t_val  = '0;
    case (st_q)
      ST_IDLE: if (start) begin
        t_load = 1'b1;
        if (start_wr) st_nx = ST_WR_SET;
        else begin st_nx = ST_RD; t_val = LD_RD; end
      end
      ST_RD: if (t_zero) begin st_nx = ST_RD_HZ; t_load = 1'b1; t_val = LD_HZ; end
      ST_RD_HZ: if (t_zero) st_nx = ST_IDLE;
      ST_WR_SET: if (t_zero) begin st_nx = ST_WR_PULSE; t_load = 1'b1; t_val = LD_WP; end
      ST_WR_PULSE: if (t_zero) begin st_nx = ST_WR_REC; t_load = 1'b1; t_val = LD_REC; end
      ST_WR_REC: if (t_zero) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      strb <= '0;
    end else begin
      st_q <= st_nx;
      strb <= strobe_of(st_nx);
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign capture = (st_q == ST_RD) && t_zero;

  AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR_PULSE && $past(st_q) != ST_WR_PULSE) |-> $past(st_q) == ST_WR_SET); // R4
  AST_READ_EXIT_TO_HZ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_RD && st_q != ST_RD) |-> st_q == ST_RD_HZ); // R7
endmodule

// File: rtl/sram_bus_io.sv
`timescale 1ns/1ps
module sram_bus_io #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_RSP_NOT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !rsp_valid); // R9
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 8000,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_CS_NS = 70,
  parameter int T_OE_NS = 40,
  parameter int T_HZ_NS = 20,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_CW_NS = 60,
  parameter int T_AW_NS = 60,
  parameter int T_DW_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC  = imax(imax(ns2cyc(T_RC_NS, CLK_PS), ns2cyc(T_AA_NS, CLK_PS)),
                                imax(ns2cyc(T_CS_NS, CLK_PS), ns2cyc(T_OE_NS, CLK_PS)));
  localparam int HZ_CYC  = ns2cyc(T_HZ_NS, CLK_PS);
  localparam int WP_CYC  = imax(imax(ns2cyc(T_WP_NS, CLK_PS), ns2cyc(T_CW_NS, CLK_PS)),
                                imax(ns2cyc(T_AW_NS, CLK_PS), ns2cyc(T_DW_NS, CLK_PS)));
  localparam int REC_CYC = imax(1, ns2cyc(T_WC_NS, CLK_PS) - WP_CYC - 1);
  localparam int CNT_W   = width_for(imax(imax(RD_CYC, HZ_CYC), imax(WP_CYC, REC_CYC)));

  strobe_t strb;
  logic    idle, rd_capture_ev;
  wire     accept_ev = req_valid & idle;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept_ev), .start_wr(req_write),
    .idle(idle), .capture(rd_capture_ev), .strb(strb)
  );

  sram_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk(clk), .rst_n(rst_n), .accept(accept_ev), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(rd_capture_ev), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  assign req_ready = idle;
  assign mem_cs1_n = ~strb.sel;
  assign mem_cs2   = strb.sel;
  assign mem_we_n  = ~strb.wr;
  assign mem_oe_n  = ~strb.oe;
  assign mem_dq_oe = strb.drv;

  wire mem_selected = ~mem_cs1_n & mem_cs2;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs1_n && !mem_cs2 && !mem_dq_oe)); // R2
  AST_SEL_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_selected)); // R4
  AST_DRV_ON_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $fell(mem_we_n)); // R5
  AST_DRV_OFF_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> $rose(mem_we_n)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_selected && $past(mem_selected)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R6
  AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)); // R3
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R4
endmodule

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;
  localparam int PER_PS = 8000;

  function automatic int up_cyc(input int ns);
    int q;
    q = (ns * 1000) / PER_PS;
    if (q * PER_PS < ns * 1000) q = q + 1;
    if (q == 0) q = 1;
    return q;
  endfunction
  function automatic int big(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  localparam int RD  = big(up_cyc(70), up_cyc(70), up_cyc(70), up_cyc(40));
  localparam int HZ  = up_cyc(20);
  localparam int WP  = big(up_cyc(50), up_cyc(60), up_cyc(60), up_cyc(30));
  localparam int REC = (up_cyc(70) > WP + 1) ? up_cyc(70) - WP - 1 : 1;
  localparam int RD_TOT = RD + HZ;
  localparam int WR_TOT = 1 + WP + REC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = '0;
  logic [17:0] mem_addr;

  always #4 clk = ~clk;

  sram_strobe_ctrl u_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int total = 0, bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model of the host side ----------------
  logic [7:0] ref_mem [int];
  int due_q[$];
  logic [7:0] dat_q[$];
  int cyc = 0, busy_until = 0;
  bit run = 1'b0;

  always @(negedge clk) begin
    if (run) begin
      cyc++;
      chk("R9 ready timing", int'(req_ready), int'(cyc >= busy_until));
      if (req_ready) chk("R2 deselected when ready", {mem_cs1_n, mem_cs2, mem_dq_oe}, 3'b100);
      if (due_q.size() > 0 && due_q[0] <= cyc) begin
        chk("R3 rsp_valid on due cycle", int'(rsp_valid), int'(due_q[0] == cyc));
        if (due_q[0] == cyc) chk("R3 read data", rsp_rdata, dat_q[0]);
        void'(due_q.pop_front());
        void'(dat_q.pop_front());
      end else begin
        chk("R3 no stray rsp_valid", int'(rsp_valid), 0);
      end
      if (req_valid && req_ready) begin
        if (req_write) begin
          ref_mem[int'(req_addr)] = req_wdata;
          busy_until = cyc + WR_TOT + 1;
        end else begin
          due_q.push_back(cyc + RD + 1);
          dat_q.push_back(ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00);
          busy_until = cyc + RD_TOT + 1;
        end
      end
    end
  end

  // ---------------- behavioural memory model ----------------
  logic [7:0] arr [int];
  int wr_len = 0, rd_len = 0, hz_left = 0;
  logic [17:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_byte = '0;
  bit mdrive = 1'b0;

  always @(negedge clk) begin
    logic sel, wr, rd;
    logic [7:0] cur;
    if (run) begin
      sel = !mem_cs1_n && mem_cs2;
      wr  = sel && !mem_we_n;
      rd  = sel && mem_we_n && !mem_oe_n;
      if (!mem_we_n && !mem_oe_n) chk("R4 OE high during write", 1, 0);
      if (wr) begin
        if (wr_len > 0 && mem_addr != wr_addr) chk("R6 write address held", mem_addr, wr_addr);
        if (wr_len > 0 && mem_dq_out != wr_byte) chk("R6 write data held", mem_dq_out, wr_byte);
        wr_len++;
        wr_addr = mem_addr;
        wr_byte = mem_dq_out;
        chk("R5 driver on during write", int'(mem_dq_oe), 1);
      end else begin
        if (wr_len > 0) begin
          chk("R4 write pulse cycles", wr_len, WP);
          arr[int'(wr_addr)] = wr_byte;
          wr_len = 0;
        end
        chk("R5 driver off outside write", int'(mem_dq_oe), 0);
      end
      if (rd) begin
        if (rd_len > 0 && mem_addr == rd_addr) rd_len++;
        else rd_len = 1;
        rd_addr = mem_addr;
        cur = arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : 8'h00;
        mem_dq_in = (rd_len >= RD) ? cur : ~cur;
        mdrive = 1'b1;
        hz_left = HZ;
      end else begin
        if (rd_len > 0) begin
          chk("R3 read strobe cycles", rd_len, RD);
          rd_len = 0;
        end
        if (hz_left > 0) begin
          mdrive = 1'b1;
          hz_left--;
        end else begin
          mdrive = 1'b0;
          mem_dq_in = 8'h00;
        end
      end
      if (mdrive && mem_dq_oe) chk("R7 bus contention", 1, 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input bit wr, input logic [17:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;            // R6: scramble host inputs after acceptance
    req_addr  = ~a;
    req_wdata = ~d;
    req_write = ~wr;
  endtask

  task automatic settle;
    repeat (RD_TOT + 4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs1_n", mem_cs1_n, 1);
    chk("R1 cs2", mem_cs2, 0);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    run = 1'b1;

    op(1'b1, 18'h00000, 8'hA5);
    op(1'b1, 18'h3FFFF, 8'hFF);
    op(1'b1, 18'h12345, 8'h00);
    op(1'b0, 18'h00000, 8'h00);
    op(1'b0, 18'h3FFFF, 8'h00);
    op(1'b0, 18'h12345, 8'h00);
    settle();
    // back-to-back turnarounds (R7, R8)
    op(1'b1, 18'h00777, 8'h3C);
    op(1'b0, 18'h00777, 8'h00);
    op(1'b1, 18'h00777, 8'hC3);
    op(1'b0, 18'h00777, 8'h00);
    op(1'b0, 18'h00000, 8'h00);
    settle();
    for (int i = 0; i < 60; i++) begin
      logic [17:0] a;
      a = {$urandom_range(0, 1) == 1 ? 10'h3FF : 10'h000, 5'd0, 3'($urandom_range(0, 7))};
      op(1'($urandom_range(0, 1)), a, 8'($urandom));
      if ((i % 7) == 3) repeat (2) @(posedge clk);
    end
    settle();
    chk("R9 queue drained", due_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule